// File: doc/BRIEF.md
# Write-Protected Watchdog Timer Controller

This block supervises a processor. It uses one 8-bit control and status register and counts ticks of a slow timebase, nominally 32.768 kHz. Software must write the register with the enable bit set before the timeout expires. If it does not, the block either sends a one-cycle request to reset the system, or raises an interrupt request that stays asserted until it is acknowledged. A mode bit in the register picks between the two. In interrupt mode the count restarts after each expiry, so the block can also serve as a periodic timer.

The register is guarded against stray writes. A retiring instruction first sets the unlock bit. The instruction that retires next must be the register write. A write that arrives without the unlock is dropped entirely. A 4-bit prescale field sets the timeout in powers of two. One extra code fires at once, and the codes above it never fire. A power-supply-monitor event turns the watchdog off. A timeout sets a status flag, and that flag survives the reset the watchdog itself requests.

Top module: `guarded_wdt`

## Requirements
- R1: After hardware reset the register reads 0x10 (prescale 1, all flag bits 0), and both request outputs are low.
- R2: Register bits are prescale [7:4], interrupt mode [3], status [2], enable [1] and unlock [0]. A retire with `arm_i` high sets the unlock bit, and cycles with no retire leave it set. A write retiring next takes effect, and the unlock bit then reads 0.
- R3: A write retired while the register is locked changes no bit. A retire of any instruction other than the arming one drops the unlock.
- R4: With prescale p in 0..7, the watchdog expires on the 2^(p+BASE_SHIFT)-th tick after the accepted write. Cycles without `tick_i` do not advance the count.
- R5: An accepted write with the enable bit set restarts the count from zero.
- R6: In reset mode (bit 3 = 0), expiry gives a `wdt_rst_o` pulse one cycle wide. It clears the enable bit, sets the status bit and leaves the prescale unchanged.
- R7: In interrupt mode (bit 3 = 1), expiry sets `wdt_irq_o`, which stays high until `irq_ack_i`. The enable bit stays set and the count restarts, so expiry repeats every period.
- R8: Prescale 8 expires in the cycle after the watchdog is enabled, without any tick.
- R9: Prescale 9 to 15 never expires.
- R10: The status bit is set by expiry. A write of 0 clears it, and a write of 1 leaves it unchanged. A watchdog reset does not clear it, but a hardware reset does.
- R11: A `psm_evt_i` pulse clears the enable bit, and no expiry follows.
- R12: Writing 0x72 after an unlock reads back 0x72: prescale 7, reset mode, enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| tick_i | input | 1 | One-cycle timebase tick |
| retire_i | input | 1 | An instruction retires this cycle |
| arm_i | input | 1 | The retiring instruction sets the unlock bit |
| wr_i | input | 1 | The retiring instruction writes the register |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Current register contents |
| psm_evt_i | input | 1 | Power-supply-monitor event |
| irq_ack_i | input | 1 | Interrupt acknowledge strobe |
| wdt_rst_o | output | 1 | System reset request pulse |
| wdt_irq_o | output | 1 | Watchdog interrupt request |

## Verification
Assertions check on every cycle the properties that need no history. The reset request lasts one cycle. A held interrupt is never dropped without an acknowledge. A locked write changes nothing, and the unlock is lost on any other retire. Reserved prescale codes never expire, and the counter stays inside the selected period. A reset-mode expiry clears the enable bit and sets the status bit. The exact timeout length for each prescale code can only be shown by the bench's scenarios, which sweep every code with a small timebase shift. The same holds for the kick restarting the period, the interrupt repeating, and status surviving a watchdog reset but not a hardware reset.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int PRE_W   = 4;
  localparam int PRE_MAX = 7;                // largest timed prescale code
  localparam logic [PRE_W-1:0] PRE_IMM = PRE_W'(PRE_MAX + 1);
  localparam logic [PRE_W-1:0] PRE_RST = PRE_W'(1);

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic             irq_mode;
    logic             status;
    logic             en;
  } wdg_cfg_t;
endpackage

// File: rtl/wdg_guard.sv
module wdg_guard (
  input  logic clk,
  input  logic rst,
  input  logic retire_i,
  input  logic arm_i,
  input  logic wr_i,
  output logic unlock_o,
  output logic accept_o
);
  logic unlock_q;

  assign accept_o = retire_i & wr_i & unlock_q;
  assign unlock_o = unlock_q;

  always_ff @(posedge clk) begin
    if (rst)
      unlock_q <= 1'b0;
    else if (accept_o)
      unlock_q <= 1'b0;
    else if (retire_i)
      unlock_q <= arm_i;
  end

  // R3
  lost_unlock_chk: assert property (@(posedge clk) disable iff (rst)
    (retire_i && !arm_i) |=> !unlock_q);

  // R2
  consumed_unlock_chk: assert property (@(posedge clk) disable iff (rst)
    accept_o |=> !unlock_q);
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
  import wdg_pkg::*;
#(
  parameter int BASE_SHIFT = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic             hold_i,
  input  logic [PRE_W-1:0] pre_i,
  output logic             expire_o
);
  localparam int CNT_W = BASE_SHIFT + PRE_MAX;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_m;
  logic             timed;
  logic             timed_hit;
  logic             instant;

  always_comb begin
    timed  = (int'(pre_i) <= PRE_MAX);
    last_m = timed ? CNT_W'((64'd1 << (BASE_SHIFT + int'(pre_i))) - 64'd1) : '0;
    timed_hit = timed && tick_i && (cnt_q == last_m);
    instant   = (pre_i == PRE_IMM);
    expire_o  = en_i && !restart_i && !hold_i && (timed_hit || instant);
  end

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (!en_i || restart_i || expire_o)
      cnt_q <= '0;
    else if (tick_i && timed)
      cnt_q <= cnt_q + 1'b1;
  end

  // R9
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(pre_i) > PRE_MAX + 1) |-> !expire_o);

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (en_i && timed) |-> (cnt_q <= last_m));

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/wdg_respond.sv
module wdg_respond (
  input  logic clk,
  input  logic rst,
  input  logic expire_i,
  input  logic irq_mode_i,
  input  logic irq_ack_i,
  output logic rst_req_o,
  output logic irq_req_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req_o <= 1'b0;
      irq_req_o <= 1'b0;
    end else begin
      rst_req_o <= expire_i & ~irq_mode_i;
      irq_req_o <= (expire_i & irq_mode_i) | (irq_req_o & ~irq_ack_i);
    end
  end

  // R6
  rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |=> !rst_req_o);

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_req_o && !irq_ack_i) |=> irq_req_o);
endmodule

// File: rtl/guarded_wdt.sv
module guarded_wdt
  import wdg_pkg::*;
#(
  parameter int BASE_SHIFT = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       retire_i,
  input  logic       arm_i,
  input  logic       wr_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  input  logic       psm_evt_i,
  input  logic       irq_ack_i,
  output logic       wdt_rst_o,
  output logic       wdt_irq_o
);
  wdg_cfg_t cfg_q, cfg_d;
  logic     unlock;
  logic     accept;
  logic     expire;

  wdg_guard guard_i (
    .clk      (clk),
    .rst      (rst),
    .retire_i (retire_i),
    .arm_i    (arm_i),
    .wr_i     (wr_i),
    .unlock_o (unlock),
    .accept_o (accept)
  );

  wdg_counter #(.BASE_SHIFT(BASE_SHIFT)) counter_i (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick_i),
    .en_i      (cfg_q.en),
    .restart_i (accept),
    .hold_i    (psm_evt_i),
    .pre_i     (cfg_q.pre),
    .expire_o  (expire)
  );

  wdg_respond respond_i (
    .clk        (clk),
    .rst        (rst),
    .expire_i   (expire),
    .irq_mode_i (cfg_q.irq_mode),
    .irq_ack_i  (irq_ack_i),
    .rst_req_o  (wdt_rst_o),
    .irq_req_o  (wdt_irq_o)
  );

  always_comb begin
    cfg_d = cfg_q;
    if (accept) begin
      cfg_d.pre      = wr_data_i[7:4];
      cfg_d.irq_mode = wr_data_i[3];
      cfg_d.status   = cfg_q.status & wr_data_i[2];
      cfg_d.en       = wr_data_i[1];
    end
    if (expire) begin
      cfg_d.status = 1'b1;
      if (!cfg_q.irq_mode) cfg_d.en = 1'b0;
    end
    if (psm_evt_i) cfg_d.en = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      cfg_q.pre <= PRE_RST;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assign rd_data_o = {cfg_q, unlock};

  // R3
  locked_write_chk: assert property (@(posedge clk) disable iff (rst)
    (retire_i && wr_i && !unlock && !expire && !psm_evt_i) |=> $stable(cfg_q));

  // R10
  status_set_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> cfg_q.status);

  // R6
  reset_mode_off_chk: assert property (@(posedge clk) disable iff (rst)
    (expire && !cfg_q.irq_mode) |=> !cfg_q.en);
endmodule

// File: tb/guarded_wdt_tb_top.sv
module guarded_wdt_tb_top;
  localparam int SHIFT = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0, retire = 1'b0, arm = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       psm = 1'b0, ack = 1'b0;
  logic       rreq, ireq;
  int         checks = 0;
  int         errors = 0;
  int         cycles = 0;

  always #2 clk = ~clk;

  guarded_wdt #(.BASE_SHIFT(SHIFT)) dut_i (
    .clk(clk), .rst(rst), .tick_i(tick), .retire_i(retire), .arm_i(arm),
    .wr_i(wr), .wr_data_i(wdata), .rd_data_o(rdata), .psm_evt_i(psm),
    .irq_ack_i(ack), .wdt_rst_o(rreq), .wdt_irq_o(ireq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic gwrite(logic [7:0] d);
    retire = 1'b1; arm = 1'b1;
    step();
    arm = 1'b0; wr = 1'b1; wdata = d;
    step();
    wr = 1'b0; retire = 1'b0;
  endtask

  initial begin
    int seen;
    step(); step();
    rst = 1'b0;
    step();
    check("R1 reg", rdata, 8'h10);
    check("R1 outs", {rreq, ireq}, 0);

    // R3 locked write
    retire = 1'b1; wr = 1'b1; wdata = 8'hFF; step();
    wr = 1'b0; retire = 1'b0; step();
    check("R3 locked", rdata, 8'h10);
    // R3 unlock lost on another retire
    retire = 1'b1; arm = 1'b1; step();
    arm = 1'b0; retire = 1'b0;
    check("R2 unlock bit", rdata, 8'h11);
    retire = 1'b1; step();
    wr = 1'b1; wdata = 8'hFF; step();
    wr = 1'b0; retire = 1'b0;
    check("R3 lost unlock", rdata, 8'h10);
    // R2 unlock survives idle cycles
    retire = 1'b1; arm = 1'b1; step();
    arm = 1'b0; retire = 1'b0;
    step(); step(); step();
    retire = 1'b1; wr = 1'b1; wdata = 8'h00; step();
    wr = 1'b0; retire = 1'b0;
    check("R2 accepted", rdata, 8'h00);

    // R4/R6 sweep of timed codes, reset mode
    tick = 1'b1;
    for (int p = 0; p <= 7; p++) begin
      int len;
      len = 1 << (p + SHIFT);
      gwrite(8'((p << 4) | 2));
      if (p == 7) check("R12 readback", rdata, 8'h72);
      else        check("R2 write", rdata, 32'((p << 4) | 2));
      seen = 0;
      for (int k = 0; k < len - 1; k++) begin
        step();
        if (rreq || ireq) seen++;
      end
      check("R4 no early expiry", seen, 0);
      step();
      check("R6 reset pulse", rreq, 1);
      check("R6 reg after expiry", rdata, 32'((p << 4) | 4));
      check("R6 no irq", ireq, 0);
      step();
      check("R6 pulse width", rreq, 0);
    end

    // R4 tick gating
    tick = 1'b0;
    gwrite(8'h02);
    for (int k = 0; k < 50; k++) step();
    check("R4 no tick no count", rreq, 0);
    check("R10 status cleared by 0", rdata, 8'h02);
    tick = 1'b1;
    step(); step(); step();
    check("R4 gated early", rreq, 0);
    step();
    check("R4 gated expiry", rreq, 1);

    // R5 kick
    gwrite(8'h12);
    for (int k = 0; k < 6; k++) step();
    tick = 1'b0;
    gwrite(8'h12);
    tick = 1'b1;
    for (int k = 0; k < 7; k++) step();
    check("R5 kick restarts", rreq, 0);
    step();
    check("R5 expiry after kick", rreq, 1);
    step();

    // R10 write 1 keeps status, write 0 clears
    check("R10 survives wdt reset", rdata, 8'h14);
    gwrite(8'h04);
    check("R10 write 1 keeps", rdata, 8'h04);
    gwrite(8'h00);
    check("R10 write 0 clears", rdata, 8'h00);

    // R7 interrupt mode
    gwrite(8'h1A);
    for (int k = 0; k < 7; k++) step();
    check("R7 irq early", ireq, 0);
    step();
    check("R7 irq raised", ireq, 1);
    check("R7 no reset", rreq, 0);
    check("R7 reg", rdata, 8'h1E);
    ack = 1'b1; step(); ack = 1'b0;
    check("R7 ack clears", ireq, 0);
    for (int k = 0; k < 6; k++) step();
    check("R7 period gap", ireq, 0);
    step();
    check("R7 periodic", ireq, 1);
    for (int k = 0; k < 5; k++) step();
    check("R7 held", ireq, 1);
    check("R7 still enabled", rdata, 8'h1E);
    ack = 1'b1; step(); ack = 1'b0;
    gwrite(8'h00);
    step();
    check("R7 released", ireq, 0);

    // R8 immediate code
    tick = 1'b0;
    gwrite(8'h82);
    check("R8 not yet", rreq, 0);
    step();
    check("R8 immediate", rreq, 1);
    check("R8 reg", rdata, 8'h84);
    step();
    check("R8 single", rreq, 0);

    // R9 reserved codes
    tick = 1'b1;
    for (int c = 9; c <= 15; c++) begin
      gwrite(8'((c << 4) | 2));
      seen = 0;
      for (int k = 0; k < 80; k++) begin
        step();
        if (rreq || ireq) seen++;
      end
      check("R9 reserved quiet", seen, 0);
      check("R9 reg", rdata, 32'((c << 4) | 2));
    end

    // R11 supply monitor event
    gwrite(8'h02);
    step(); step();
    psm = 1'b1; step(); psm = 1'b0;
    check("R11 enable cleared", rdata, 8'h00);
    seen = 0;
    for (int k = 0; k < 20; k++) begin
      step();
      if (rreq || ireq) seen++;
    end
    check("R11 no expiry", seen, 0);

    // R10 hardware reset clears status
    gwrite(8'h02);
    for (int k = 0; k < 4; k++) step();
    check("R10 status set", rdata, 8'h04);
    rst = 1'b1; step(); rst = 1'b0; step();
    check("R10 hw reset clears", rdata, 8'h10);
    check("R1 outs after reset", {rreq, ireq}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule